// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block controls an 8-bit successive-approximation conversion inside a microcontroller. Software launches a conversion by writing 1 to the start/done bit. The block then stops the sample/hold from tracking. It derives a conversion clock from the system oscillator (divide by 2, 8 or 32) or from a separate RC clock input. It walks a trial code from the most significant bit down to the least, using one comparator bit to keep or drop each bit. When the conversion finishes, the code moves into the result register, the start/done bit drops and a sticky interrupt flag rises. Sampling resumes only after a turnaround of two conversion-clock periods.

Every sequencing decision is made in the system clock domain. The RC clock is brought in through a synchronizer, and only its rising edges are used. A conversion lasts eleven conversion-clock periods. The previous result stays readable for the whole conversion. Writing 0 to the start/done bit while it is set abandons the conversion without touching the result or the flag.

Top module: `sar_adc_seq`

## Requirements
- R1: A write of 1 to the start bit while `busy` is 0 makes `busy` read 1 and `sample_en` read 0 from the next clock onward. `sample_en` is 1 only while the block is idle.
- R2: One clock after the launch edge, `trial_code` is 0x80. Bits are resolved from bit 7 to bit 0, one per conversion-clock period. A bit is kept when `cmp_in` is 1 (input at or above the trial code) and cleared when it is 0, so a monotonic comparator yields `result` equal to the input code.
- R3: `result` keeps its previous value throughout a conversion.
- R4: On the completing edge, `result` takes the new code, `busy` falls and `irq_flag` rises.
- R5: With `clk_sel` = 00, 01 or 10 (divide by N = 2, 8 or 32), `busy` falls exactly 1 + 11·N clocks after the edge that accepted the start write.
- R6: With `clk_sel` = 11, conversion periods are counted on synchronized rising edges of `rc_clk`, after a delay of INSN_CYC system clocks. While `rc_clk` is still, the conversion does not complete.
- R7: After completion, `sample_en` stays 0 for two conversion-clock periods. In oscillator mode it rises exactly 2·N clocks after the completing edge.
- R8: A write of 0 to the start bit while `busy` is 1 clears `busy` on the next clock. `result` is not changed and `irq_flag` is not set.
- R9: `irq_flag` stays 1 until `irq_clr` is pulsed.
- R10: A write of 1 to the start bit while `busy` is 1 is ignored. The conversion timing is unchanged.
- R11: A start write accepted during the turnaround sets `busy` at once. The new conversion begins after the turnaround, and `sample_en` stays 0 in between.
- R12: `clk_sel` is sampled when a conversion launches. Changing it during the conversion has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the start/done bit |
| start_val | input | 1 | Value written to the start/done bit |
| clk_sel | input | 2 | Conversion clock source: 00 /2, 01 /8, 10 /32, 11 RC |
| irq_clr | input | 1 | Clears the interrupt flag |
| rc_clk | input | 1 | Free-running RC conversion clock, asynchronous |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `trial_code` |
| sample_en | output | 1 | 1 while the sample/hold tracks the input |
| trial_code | output | 8 | Code driven to the DAC during conversion |
| busy | output | 1 | Start/done bit as read by software |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| result | output | 8 | Result register |

## Verification
The bench measures completion latency to the exact clock for all three divider ratios. An off-by-one tick counter, or a divider that is not restarted at launch, therefore shows up as a wrong count. It drives input codes 0x00, 0xFF, 0x01 and mixed patterns. A comparator polarity slip, or a skipped or repeated bit step, would return a wrong code. It aborts mid-conversion, re-writes start while busy, changes the clock select mid-conversion and launches during the turnaround. A design that leaked the partial code, restarted the sequence, retimed itself or resumed sampling early would be caught. It stalls the RC clock to show that completion depends only on RC edges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        CK_DIV_A = 2'b00,
        CK_DIV_B = 2'b01,
        CK_DIV_C = 2'b10,
        CK_RC    = 2'b11
    } ck_src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_CONV,
        ST_TURN
    } seq_state_e;

    // conversion periods beyond the code width: one setup, two trailing
    localparam int EXTRA_TICKS = 3;
    localparam int TURN_TICKS  = 2;

    typedef struct packed {
        logic go;
        logic abort;
    } sw_cmd_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_ck_gen.sv
module sar_ck_gen
    import sar_seq_pkg::*;
#(
    parameter int DIV_A       = 2,
    parameter int DIV_B       = 8,
    parameter int DIV_C       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    restart,
    input  ck_src_e src,
    input  logic    rc_clk,
    output logic    tick
);
    localparam int DIV_MAX = int'(max3(DIV_A, DIV_B, DIV_C));
    localparam int CW      = $clog2(DIV_MAX + 1);

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_lim;
    logic          osc_tick;
    logic          rc_rise;

    always_comb begin
        unique case (src)
            CK_DIV_A: div_lim = CW'(DIV_A - 1);
            CK_DIV_B: div_lim = CW'(DIV_B - 1);
            CK_DIV_C: div_lim = CW'(DIV_C - 1);
            default:  div_lim = CW'(DIV_A - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            div_cnt <= '0;
        else if (div_cnt == div_lim)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + CW'(1);
    end

    // synchronizer chain plus one stage for edge detection
    logic [SYNC_STAGES:0] rc_pipe;
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) rc_pipe[0] <= 1'b0;
                    else     rc_pipe[0] <= rc_clk;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) rc_pipe[g] <= 1'b0;
                    else     rc_pipe[g] <= rc_pipe[g-1];
                end
            end
        end
    endgenerate

    assign rc_rise  = rc_pipe[SYNC_STAGES-1] && !rc_pipe[SYNC_STAGES];
    assign osc_tick = (div_cnt == div_lim) && !restart;
    assign tick     = (src == CK_RC) ? (rc_rise && !restart) : osc_tick;

    AST_OSC_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick && src != CK_RC && !restart) |=> !tick); // R5

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
    import sar_seq_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int TICKS  = CODE_W + EXTRA_TICKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] trial,
    output logic              last
);
    localparam int CNTW = $clog2(TICKS);
    localparam int IW   = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    logic [CNTW-1:0]   cnt;
    logic [CODE_W-1:0] trial_nx;
    logic [IW-1:0]     idx;
    logic              decide;

    always_comb begin
        decide   = (cnt >= CNTW'(1)) && (cnt <= CNTW'(CODE_W));
        idx      = IW'(CODE_W - int'(cnt));
        trial_nx = trial;
        if (decide) begin
            if (!cmp_in)
                trial_nx[idx] = 1'b0;
            if (idx != '0)
                trial_nx[idx - IW'(1)] = 1'b1;
        end
    end

    assign last = step && (cnt == CNTW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            trial <= '0;
            cnt   <= '0;
        end else if (load) begin
            trial <= {1'b1, {(CODE_W-1){1'b0}}};
            cnt   <= '0;
        end else if (step) begin
            trial <= trial_nx;
            cnt   <= last ? '0 : cnt + CNTW'(1);
        end
    end

    AST_ONE_BIT_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ($countones(trial ^ $past(trial)) <= 2)); // R2
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CNTW'(TICKS)); // R5

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int INSN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_val,
    input  ck_src_e           sel_in,
    input  logic              irq_clr,
    input  logic              tick,
    input  logic              last,
    input  logic [CODE_W-1:0] trial,
    output ck_src_e           sel_q,
    output logic              load,
    output logic              step,
    output logic              restart,
    output logic              sample_en,
    output logic              busy,
    output logic              irq,
    output logic [CODE_W-1:0] result
);
    localparam int DW = $clog2(INSN_CYC + 1);
    localparam int TW = (TURN_TICKS > 1) ? $clog2(TURN_TICKS) : 1;

    seq_state_e    state;
    sw_cmd_t       cmd;
    logic [DW-1:0] dly_cnt;
    logic [DW-1:0] dly_lim;
    logic [TW-1:0] turn_cnt;
    logic          pend;
    logic          nxt_pend;
    logic          done;

    always_comb begin
        cmd.go    = start_wr && start_val && !busy;
        cmd.abort = start_wr && !start_val && busy;
        done      = last && !cmd.abort;
        dly_lim   = (sel_q == CK_RC) ? DW'(INSN_CYC - 1) : '0;
        step      = tick && (state == ST_CONV);
        load      = (state == ST_DELAY) && (dly_cnt == dly_lim) && !cmd.abort;
        restart   = (state == ST_IDLE) || (state == ST_DELAY) || cmd.abort;
        sample_en = (state == ST_IDLE);
        nxt_pend  = cmd.go ? 1'b1 : (cmd.abort ? 1'b0 : pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sel_q    <= CK_DIV_A;
            busy     <= 1'b0;
            pend     <= 1'b0;
            dly_cnt  <= '0;
            turn_cnt <= '0;
            irq      <= 1'b0;
            result   <= '0;
        end else begin
            if (done)         irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
            if (done) result <= trial;

            unique case (state)
                ST_IDLE: begin
                    if (cmd.go) begin
                        state   <= ST_DELAY;
                        busy    <= 1'b1;
                        sel_q   <= sel_in;
                        dly_cnt <= '0;
                    end
                end
                ST_DELAY: begin
                    if (cmd.abort) begin
                        state    <= ST_TURN;
                        busy     <= 1'b0;
                        turn_cnt <= '0;
                    end else if (dly_cnt == dly_lim) begin
                        state <= ST_CONV;
                    end else begin
                        dly_cnt <= dly_cnt + DW'(1);
                    end
                end
                ST_CONV: begin
                    if (cmd.abort || done) begin
                        state    <= ST_TURN;
                        busy     <= 1'b0;
                        turn_cnt <= '0;
                    end
                end
                ST_TURN: begin
                    busy <= nxt_pend;
                    pend <= nxt_pend;
                    if (tick) begin
                        if (turn_cnt == TW'(TURN_TICKS - 1)) begin
                            turn_cnt <= '0;
                            pend     <= 1'b0;
                            if (nxt_pend) begin
                                state   <= ST_DELAY;
                                sel_q   <= sel_in;
                                dly_cnt <= '0;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            turn_cnt <= turn_cnt + TW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HOLDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sample_en); // R1
    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(result)); // R3
    AST_COMPLETE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (last && !start_wr) |=> (!busy && irq)); // R4
    AST_SAMPLE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_en) |-> $past(tick)); // R7
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (busy && start_wr && !start_val) |=> (!busy && $stable(result))); // R8
    AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (busy && start_wr && !start_val && !irq) |=> !irq); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int DIV_A    = 2,
    parameter int DIV_B    = 8,
    parameter int DIV_C    = 32,
    parameter int INSN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic              start_val,
    input  logic [1:0]        clk_sel,
    input  logic              irq_clr,
    input  logic              rc_clk,
    input  logic              cmp_in,
    output logic              sample_en,
    output logic [CODE_W-1:0] trial_code,
    output logic              busy,
    output logic              irq_flag,
    output logic [CODE_W-1:0] result
);
    localparam int TICKS = CODE_W + EXTRA_TICKS;

    ck_src_e sel_q;
    logic    tick;
    logic    restart;
    logic    load;
    logic    step;
    logic    last;

    sar_ck_gen #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(2)
    ) u_ck (
        .clk(clk), .rst(rst), .restart(restart), .src(sel_q),
        .rc_clk(rc_clk), .tick(tick)
    );

    sar_bit_engine #(.CODE_W(CODE_W), .TICKS(TICKS)) u_bits (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .cmp_in(cmp_in), .trial(trial_code), .last(last)
    );

    sar_seq_ctrl #(.CODE_W(CODE_W), .INSN_CYC(INSN_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_val(start_val),
        .sel_in(ck_src_e'(clk_sel)), .irq_clr(irq_clr), .tick(tick),
        .last(last), .trial(trial_code), .sel_q(sel_q), .load(load),
        .step(step), .restart(restart), .sample_en(sample_en),
        .busy(busy), .irq(irq_flag), .result(result)
    );

endmodule

// File: tb/sar_adc_seq_test.sv
module sar_adc_seq_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_wr = 1'b0;
    logic       start_val = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       irq_clr = 1'b0;
    logic       rc_clk = 1'b0;
    logic       rc_run = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       cmp_in;
    logic       sample_en;
    logic [7:0] trial_code;
    logic       busy;
    logic       irq_flag;
    logic [7:0] result;
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    assign cmp_in = (vin >= trial_code);

    sar_adc_seq uut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_val(start_val),
        .clk_sel(clk_sel), .irq_clr(irq_clr), .rc_clk(rc_clk),
        .cmp_in(cmp_in), .sample_en(sample_en), .trial_code(trial_code),
        .busy(busy), .irq_flag(irq_flag), .result(result)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            if (rc_run) rc_clk = ~rc_clk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_start(input logic v);
        @(negedge clk);
        start_wr  = 1'b1;
        start_val = v;
        @(negedge clk);
        start_wr  = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset busy", busy, 0);
        chk("R1 reset sample_en", sample_en, 1);
        chk("R9 reset irq", irq_flag, 0);
        chk("R3 reset result", result, 0);
    endtask

    // oscillator-mode conversion with exact latency and turnaround
    task automatic t_osc(input logic [1:0] sel, input logic [7:0] v, input int div);
        int n;
        int m;
        logic [7:0] prev;
        clear_irq();
        prev = result;
        vin = v;
        clk_sel = sel;
        write_start(1'b1);
        n = 1;
        chk("R1 busy after start", busy, 1);
        chk("R1 sample_en low", sample_en, 0);
        @(negedge clk); n++;
        chk("R2 first trial 0x80", trial_code, 8'h80);
        while (busy && n < 2000) begin
            @(negedge clk); n++;
            if (n == div * 5) chk("R3 old result held", result, prev);
        end
        chk("R5 latency", n, 2 + 11 * div);
        chk("R2 result code", result, v);
        chk("R4 irq set", irq_flag, 1);
        m = 0;
        while (!sample_en && m < 2000) begin
            @(negedge clk); m++;
        end
        chk("R7 turnaround", m, 2 * div);
    endtask

    task automatic t_irq_sticky();
        repeat (20) @(negedge clk);
        chk("R9 irq held", irq_flag, 1);
        clear_irq();
        chk("R9 irq cleared", irq_flag, 0);
    endtask

    task automatic t_abort();
        logic [7:0] prev;
        clear_irq();
        prev = result;
        vin = 8'h3C;
        clk_sel = 2'b01;
        write_start(1'b1);
        repeat (30) @(negedge clk);
        write_start(1'b0);
        chk("R8 busy cleared", busy, 0);
        repeat (40) @(negedge clk);
        chk("R8 result unchanged", result, prev);
        chk("R8 no irq", irq_flag, 0);
        chk("R8 back to sampling", sample_en, 1);
    endtask

    task automatic t_ignore_restart();
        int n;
        clear_irq();
        vin = 8'h5A;
        clk_sel = 2'b00;
        write_start(1'b1);
        n = 1;
        while (n < 10) begin @(negedge clk); n++; end
        start_wr = 1'b1; start_val = 1'b1;
        @(negedge clk); n++;
        start_wr = 1'b0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk("R10 latency unchanged", n, 24);
        chk("R10 result", result, 8'h5A);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_sel_change();
        int n;
        clear_irq();
        vin = 8'hC3;
        clk_sel = 2'b01;
        write_start(1'b1);
        n = 1;
        while (n < 5) begin @(negedge clk); n++; end
        clk_sel = 2'b10;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        chk("R12 latency keeps launch select", n, 90);
        chk("R12 result", result, 8'hC3);
        repeat (20) @(negedge clk);
        clk_sel = 2'b00;
    endtask

    task automatic t_pending();
        int n;
        int rose;
        t_osc(2'b01, 8'h11, 8);
        clear_irq();
        // run another and launch while in turnaround
        vin = 8'h22;
        write_start(1'b1);
        while (busy) @(negedge clk);
        vin = 8'h99;
        write_start(1'b1);
        chk("R11 busy set in turnaround", busy, 1);
        rose = 0;
        n = 0;
        while (busy && n < 2000) begin
            @(negedge clk); n++;
            if (sample_en) rose = 1;
        end
        chk("R11 no sampling between", rose, 0);
        chk("R11 queued result", result, 8'h99);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_rc();
        int n;
        logic [7:0] prev;
        clear_irq();
        prev = result;
        vin = 8'h6E;
        clk_sel = 2'b11;
        rc_run = 1'b0;
        write_start(1'b1);
        repeat (100) @(negedge clk);
        chk("R6 stalls without rc edges", busy, 1);
        chk("R6 result held while stalled", result, prev);
        rc_run = 1'b1;
        n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        chk("R6 rc conversion done", busy, 0);
        chk("R6 rc result", result, 8'h6E);
        chk("R6 rc irq", irq_flag, 1);
        n = 0;
        while (!sample_en && n < 3000) begin @(negedge clk); n++; end
        chk("R7 rc turnaround ends", sample_en, 1);
        rc_run = 1'b0;
        clk_sel = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_osc(2'b00, 8'hA5, 2);
        t_irq_sticky();
        t_osc(2'b01, 8'h00, 8);
        t_osc(2'b10, 8'hFF, 32);
        t_osc(2'b00, 8'h01, 2);
        t_abort();
        t_ignore_restart();
        t_sel_change();
        t_pending();
        t_rc();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 190000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule